// File: doc/BRIEF.md
# Pin Bank with Bit-Masked Half-Word Writes

This block is a bank of 32 general-purpose pins controlled through a small memory-mapped register bus. It keeps an output-level register and a drive-enable register, passes both straight to the pad ring, and presents the synchronized pad levels as a read-only input word. It also returns a fixed identification constant.

Each 32-bit control register is stored as two 16-bit halves. The half for the lower pins sits at the register's base offset, and the half for the upper pins sits four bytes above it. A write to either half carries its data in the low 16 bits and a per-bit enable in the high 16 bits. Software can therefore set or clear any single pin without reading the register first, and it never disturbs pins that another agent owns. Interrupt and debounce logic live in neighbouring blocks. In this block their offsets decode as empty.

Top module: `gpio_bank`

## Requirements
- R1: While `rst` is high at a rising edge, the output-level and drive-enable registers clear to 0. `pad_out` and `pad_oe` are 0 one edge later, so every pin starts as an input.
- R2: A write to a half word updates stored bit n only when `bus_wdata[n+16]` is 1, and loads it with `bus_wdata[n]`. Bits whose enable is 0 keep their value.
- R3: The half at the base offset holds pins 0–15 and the half at base+4 holds pins 16–31. The output-level register has its base at 0x00 and the drive-enable register has its base at 0x08. A write to one half never changes the other half.
- R4: Reading a half word returns its 16 stored bits in `bus_rdata[15:0]`, with `bus_rdata[31:16]` equal to 0.
- R5: `pad_out[i]` equals output-level bit i. `pad_oe[i]` equals drive-enable bit i, where 1 means the pin drives and 0 means it is an input. Both follow the edge that accepts the write.
- R6: Offset 0x70 returns all 32 pad levels through a two-flop synchronizer. After a change on `pad_in`, a read sampled at the second rising edge still returns the old level. A read sampled at the third edge returns the new level.
- R7: Offset 0x78 always reads 0x01000C2B. Writes to it have no effect.
- R8: Writes to offset 0x70, offset 0x78, any other offset outside 0x00–0x0F, or any address with nonzero bits [1:0] leave `pad_out` and `pad_oe` unchanged. Reads of such unmapped offsets return 0.
- R9: `bus_rdata` is loaded at the rising edge that samples `bus_rd` high, and holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write word: enables in [31:16], data in [15:0] |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NPINS (32) | Asynchronous pad levels |
| pad_out | output | NPINS (32) | Pad output levels |
| pad_oe | output | NPINS (32) | Pad drive enables, 1 = output |

## Verification
The bench sweeps a single-bit enable across every bit of both halves of both registers. A design that ignored the enable, or that stored data into the wrong half, would corrupt neighbouring pins and fail the running model. It writes all ones to every other word offset, and to a misaligned address, to catch a loose decode that aliases the interrupt space onto the pin registers. It reads the input word at the second and at the third edge after each pad change. This pins the synchronizer to exactly two stages, and it also checks that the upper read half is zero and that the read data holds between strobes.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam logic [31:0] BANK_ID_WORD = 32'h0100_0C2B;

  localparam int OFS_DOUT = 'h00;
  localparam int OFS_DIR  = 'h08;
  localparam int OFS_PINS = 'h70;
  localparam int OFS_ID   = 'h78;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DOUT,
    SEL_DIR,
    SEL_PINS,
    SEL_ID
  } reg_sel_e;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NHALF  = 2,
  parameter int HIDX_W = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [HIDX_W-1:0] hidx
);

  localparam int SPAN = NHALF * 4;

  logic [ADDR_W-1:0] off_dout;
  logic [ADDR_W-1:0] off_dir;
  logic              in_dout;
  logic              in_dir;

  always_comb begin
    off_dout = addr - ADDR_W'(OFS_DOUT);
    off_dir  = addr - ADDR_W'(OFS_DIR);
    in_dout  = (int'(off_dout) < SPAN) && (addr[1:0] == 2'b00);
    in_dir   = (int'(off_dir)  < SPAN) && (addr[1:0] == 2'b00);
    sel      = SEL_NONE;
    hidx     = '0;
    if (in_dout) begin
      sel  = SEL_DOUT;
      hidx = off_dout[2 +: HIDX_W];
    end else if (in_dir) begin
      sel  = SEL_DIR;
      hidx = off_dir[2 +: HIDX_W];
    end else if (addr == ADDR_W'(OFS_PINS)) begin
      sel = SEL_PINS;
    end else if (addr == ADDR_W'(OFS_ID)) begin
      sel = SEL_ID;
    end
  end

endmodule

// File: rtl/gpio_masked_reg.sv
module gpio_masked_reg #(
  parameter int HALF_W = 16,
  parameter int NHALF  = 2,
  parameter int HIDX_W = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [HIDX_W-1:0]         hidx,
  input  logic [2*HALF_W-1:0]       wword,
  output logic [NHALF*HALF_W-1:0]   q
);

  logic [HALF_W-1:0] wr_data;
  logic [HALF_W-1:0] wr_en;

  assign wr_data = wword[HALF_W-1:0];
  assign wr_en   = wword[2*HALF_W-1:HALF_W];

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic [HALF_W-1:0] hq;
    always_ff @(posedge clk) begin
      if (rst) begin
        hq <= '0;
      end else if (we && (hidx == HIDX_W'(h))) begin
        hq <= (hq & ~wr_en) | (wr_data & wr_en);
      end
    end
    assign q[h*HALF_W +: HALF_W] = hq;
  end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int HALF_W = 16,
  parameter int ADDR_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [2*HALF_W-1:0]   bus_wdata,
  output logic [2*HALF_W-1:0]   bus_rdata,
  input  logic [NPINS-1:0]      pad_in,
  output logic [NPINS-1:0]      pad_out,
  output logic [NPINS-1:0]      pad_oe
);

  localparam int DATA_W = 2 * HALF_W;
  localparam int NHALF  = NPINS / HALF_W;
  localparam int HIDX_W = (NHALF > 1) ? $clog2(NHALF) : 1;

  reg_sel_e           sel;
  logic [HIDX_W-1:0]  hidx;
  logic [NPINS-1:0]   dout_q;
  logic [NPINS-1:0]   dir_q;
  logic [NPINS-1:0]   pins_s;

  gpio_addr_dec #(
    .ADDR_W (ADDR_W),
    .NHALF  (NHALF),
    .HIDX_W (HIDX_W)
  ) u_dec (
    .addr (bus_addr),
    .sel  (sel),
    .hidx (hidx)
  );

  gpio_masked_reg #(
    .HALF_W (HALF_W),
    .NHALF  (NHALF),
    .HIDX_W (HIDX_W)
  ) u_dout (
    .clk   (clk),
    .rst   (rst),
    .we    (bus_wr && (sel == SEL_DOUT)),
    .hidx  (hidx),
    .wword (bus_wdata),
    .q     (dout_q)
  );

  gpio_masked_reg #(
    .HALF_W (HALF_W),
    .NHALF  (NHALF),
    .HIDX_W (HIDX_W)
  ) u_dir (
    .clk   (clk),
    .rst   (rst),
    .we    (bus_wr && (sel == SEL_DIR)),
    .hidx  (hidx),
    .wword (bus_wdata),
    .q     (dir_q)
  );

  gpio_sync #(
    .W      (NPINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pins_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (sel)
        SEL_DOUT: bus_rdata <= {{HALF_W{1'b0}}, dout_q[int'(hidx)*HALF_W +: HALF_W]};
        SEL_DIR:  bus_rdata <= {{HALF_W{1'b0}}, dir_q[int'(hidx)*HALF_W +: HALF_W]};
        SEL_PINS: bus_rdata <= DATA_W'(pins_s);
        SEL_ID:   bus_rdata <= DATA_W'(BANK_ID_WORD);
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign pad_out = dout_q;
  assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int HALF_W = 16,
  parameter int ADDR_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [2*HALF_W-1:0] bus_wdata,
  input logic [2*HALF_W-1:0] bus_rdata,
  input logic [NPINS-1:0]    pad_out,
  input logic [NPINS-1:0]    pad_oe
);

  localparam int NHALF   = NPINS / HALF_W;
  localparam int REG_END = OFS_DIR + 4 * NHALF;

  logic [HALF_W-1:0] w_en;
  logic [HALF_W-1:0] w_dat;
  logic              wr_lo_dout;
  logic              wr_outside;
  logic              rd_half;

  assign w_en       = bus_wdata[2*HALF_W-1:HALF_W];
  assign w_dat      = bus_wdata[HALF_W-1:0];
  assign wr_lo_dout = bus_wr && (bus_addr == ADDR_W'(OFS_DOUT));
  assign wr_outside = bus_wr && ((int'(bus_addr) >= REG_END) || (bus_addr[1:0] != 2'b00));
  assign rd_half    = bus_rd && (int'(bus_addr) < REG_END) && (bus_addr[1:0] == 2'b00);

  p_rst_clear_r1: assert property (@(posedge clk)
    rst |=> (pad_out == '0 && pad_oe == '0));

  p_mask_keep_r2: assert property (@(posedge clk) disable iff (rst)
    wr_lo_dout |=> (((pad_out[HALF_W-1:0] ^ $past(pad_out[HALF_W-1:0])) & ~$past(w_en)) == '0));

  p_mask_take_r2: assert property (@(posedge clk) disable iff (rst)
    wr_lo_dout |=> ((pad_out[HALF_W-1:0] & $past(w_en)) == ($past(w_dat) & $past(w_en))));

  p_half_iso_r3: assert property (@(posedge clk) disable iff (rst)
    wr_lo_dout |=> ($stable(pad_out[NPINS-1:HALF_W]) && $stable(pad_oe)));

  p_rd_upper_r4: assert property (@(posedge clk) disable iff (rst)
    rd_half |=> (bus_rdata[2*HALF_W-1:HALF_W] == '0));

  p_id_const_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(OFS_ID)) |=> (bus_rdata == BANK_ID_WORD));

  p_ignore_wr_r8: assert property (@(posedge clk) disable iff (rst)
    wr_outside |=> ($stable(pad_out) && $stable(pad_oe)));

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind gpio_bank gpio_bank_chk #(
  .NPINS  (NPINS),
  .HALF_W (HALF_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe)
);

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_dout = '0;
  logic [31:0] exp_dir  = '0;
  logic [31:0] exp_pins = '0;
  logic [31:0] lfsr     = 32'hACE1_1234;

  always #2 clk = ~clk;

  gpio_bank dut (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd   = 1'b0;
    d        = bus_rdata;
  endtask

  function automatic logic [31:0] merge(logic [31:0] old, int half, logic [31:0] w);
    logic [31:0] r = old;
    for (int i = 0; i < 16; i++)
      if (w[16+i]) r[half*16+i] = w[i];
    return r;
  endfunction

  function automatic logic [31:0] next_rand(logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // kind 0: output level register, kind 1: drive-enable register
  task automatic reg_write(int kind, int half, logic [31:0] w, string tag);
    logic [31:0] rb;
    logic [7:0]  a = 8'((kind == 1 ? 8 : 0) + half * 4);
    bus_write(a, w);
    if (kind == 1) exp_dir = merge(exp_dir, half, w);
    else           exp_dout = merge(exp_dout, half, w);
    check({tag, " pad_out"}, pad_out, exp_dout);
    check({tag, " pad_oe"}, pad_oe, exp_dir);
    bus_read(a, rb);
    check({tag, " readback R4"}, rb,
          {16'h0, (kind == 1 ? exp_dir[half*16 +: 16] : exp_dout[half*16 +: 16])});
  endtask

  task automatic pin_probe(logic [31:0] p);
    @(negedge clk);
    pad_in   = p;
    bus_addr = 8'h70;
    bus_rd   = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R6 second edge still old", bus_rdata, exp_pins);
    @(negedge clk);
    check("R6 third edge new level", bus_rdata, p);
    bus_rd   = 1'b0;
    exp_pins = p;
  endtask

  initial begin
    logic [31:0] rb;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 pad_oe", pad_oe, 32'h0);
    for (int a = 0; a < 16; a += 4) begin
      bus_read(8'(a), rb);
      check("R1 register reads zero", rb, 32'h0);
    end

    // R2/R3/R5: walk a single enable over every bit of every half of both registers
    for (int kind = 0; kind < 2; kind++)
      for (int half = 0; half < 2; half++)
        for (int b = 0; b < 16; b++)
          reg_write(kind, half, {16'(1 << b), 16'hFFFF}, "R2 R3 R5 walk set");
    for (int kind = 0; kind < 2; kind++)
      for (int half = 0; half < 2; half++)
        for (int b = 0; b < 16; b += 3)
          reg_write(kind, half, {16'(1 << b), 16'h0000}, "R2 R3 R5 walk clear");

    // R2: all enables off changes nothing
    reg_write(0, 0, 32'h0000_FFFF, "R2 zero enable");
    reg_write(1, 1, 32'h0000_0000, "R2 zero enable");

    // R2/R5: pseudo-random data and enables
    for (int n = 0; n < 48; n++) begin
      lfsr = next_rand(lfsr);
      reg_write(n % 2, (n / 2) % 2, lfsr, "R2 R5 random");
    end

    // R8: writes to every other word offset and a misaligned address are ignored
    for (int a = 'h10; a < 'h80; a += 4) begin
      bus_write(8'(a), 32'hFFFF_FFFF);
      check("R8 pad_out unchanged", pad_out, exp_dout);
      check("R8 pad_oe unchanged", pad_oe, exp_dir);
      if (a != 'h70 && a != 'h78) begin
        bus_read(8'(a), rb);
        check("R8 unmapped read zero", rb, 32'h0);
      end
    end
    bus_write(8'h01, 32'hFFFF_0000);
    check("R8 misaligned write ignored", pad_out, exp_dout);
    bus_write(8'h0A, 32'hFFFF_0000);
    check("R8 misaligned write ignored", pad_oe, exp_dir);
    bus_read(8'h02, rb);
    check("R8 misaligned read zero", rb, 32'h0);

    // R7: identification constant, unaffected by writes
    bus_read(8'h78, rb);
    check("R7 id word", rb, 32'h0100_0C2B);

    // R6: synchronized pad levels
    pin_probe(32'hFFFF_FFFF);
    pin_probe(32'h0000_0000);
    pin_probe(32'hA5C3_0F81);
    for (int b = 0; b < 32; b += 5) pin_probe(32'(1) << b);

    // R9: read data holds while no read strobe
    bus_read(8'h78, rb);
    @(negedge clk);
    bus_addr = 8'h00;
    @(negedge clk);
    check("R9 hold without strobe", bus_rdata, 32'h0100_0C2B);
    @(negedge clk);
    check("R9 hold without strobe", bus_rdata, 32'h0100_0C2B);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule